// File: doc/BRIEF.md
# Fault-Gated 8:1 Output Serializer

This block is the last stage in front of a pin in a high-resolution PWM path. On every slow-clock cycle it takes an 8-bit unary code and shifts it out bit by bit, least significant bit first. It sends two bits in each cycle of a fast clock that runs at four times the slow rate, one bit in the high phase and one in the low phase. The position of the 0/1 boundary inside the code therefore places a pulse edge with a resolution of half a fast period. This makes the block a digital-to-time converter.

A protection input can stop the pin at any time. A trigger pulse sets a latched fault state, and the output is then held low at fast-clock granularity until an arm pulse clears the state. The serialization is modeled in ordinary flip-flops. A phase tracker in the fast domain finds the slow-clock edges, so that each word loads exactly on a slow edge.

Top module: `fault_gated_serializer`

## Requirements
- R1: While `rst` is high, `serOut` is 0. After `rst` is released, the pin carries only words sampled after the release, and all-zero words until then.
- R2: Bit i of a code (i = 0..7) occupies the i-th half fast period of its output slow cycle. Even bits appear in the high phase of `fastClk` and odd bits in the low phase, so bit 0 comes first.
- R3: A code sampled at slow edge k is driven during the slow cycle that begins at slow edge k+3. The neighbouring slow cycles carry the neighbouring codes.
- R4: Codes on consecutive slow cycles come out back to back, each one unaffected by its neighbours.
- R5: `faultTrig` (active high) is sampled on the rising edge of `fastClk`. If it is sampled high at edge f, the fast cycle that starts at f still carries data. Both halves of every fast cycle from edge f+1 onward are low until the block is re-armed.
- R6: `rearm` (active high) sampled high at fast edge a while faulted, with `faultTrig` low, clears the fault. The fast cycle that starts at a is still low, and data resumes from edge a+1.
- R7: Further `faultTrig` pulses while faulted change nothing. The output stays low, and a single `rearm` still releases it.
- R8: A `rearm` pulse while not faulted has no effect on the output.
- R9: When `faultTrig` and `rearm` are sampled high in the same fast cycle, the fault is taken.
- R10: With a 1.6 ns fast period, each 1 bit of a code adds 800 ps of high time in its slow cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slowClk | input | 1 | Word clock; rising edges aligned with rising edges of `fastClk` |
| fastClk | input | 1 | Bit clock at RATIO times the word rate; both phases carry a bit |
| rst | input | 1 | Synchronous reset, active high, for both domains |
| codeIn | input | 8 | Unary code for one slow cycle, sampled on `slowClk` |
| faultTrig | input | 1 | Fault trigger, sampled on `fastClk` |
| rearm | input | 1 | Clears a latched fault, sampled on `fastClk` |
| serOut | output | 1 | Serial pin output |

## Verification
The bench builds the block with RATIO at 4, so the code is 8 bits wide, and runs a 1.6 ns fast clock. Each bit then lasts 800 ps, and the bench can sample every one of the eight half-phase slots of a word individually. This setting lets the bench measure pulse width in 800 ps steps and see exactly at which slow edge a given code reaches the pin. Because the trigger and arm pulses are single fast cycles placed anywhere inside a word, the bench can also check the one-fast-cycle lag on both the entry into and the exit from the blanked state.

// File: rtl/serdes_gate_pkg.sv
package serdes_gate_pkg;

  // Strobes passed from the control block to the datapath
  typedef struct packed {
    logic loadWord;  // this fast edge is also a slow edge: take a new word
    logic blank;     // latched fault: force both halves of the next bit pair low
  } ctlStrobe_t;

endpackage

// File: rtl/sgs_ctl.sv
module sgs_ctl
  import serdes_gate_pkg::*;
#(
  parameter int RATIO = 4
) (
  input  logic       slowClk,
  input  logic       fastClk,
  input  logic       rst,
  input  logic       faultTrig,
  input  logic       rearm,
  output ctlStrobe_t strobe
);

  localparam int PHASE_W = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [PHASE_W-1:0] PH_LAST = PHASE_W'(RATIO - 1);
  // The fast edge that sees the slow toggle move is phase 1, so the next one is phase 2
  localparam logic [PHASE_W-1:0] PH_AFTER_SEEN = PHASE_W'(2 % RATIO);

  logic               slowToggle;
  logic               togglePrev;
  logic               synced;
  logic [PHASE_W-1:0] phase;
  logic               tripped;

  // Slow-domain marker: flips on every slow edge
  always_ff @(posedge slowClk) begin
    if (rst) slowToggle <= 1'b0;
    else     slowToggle <= ~slowToggle;
  end

  // Fast-domain phase tracker, locked to the slow edges
  always_ff @(posedge fastClk) begin
    if (rst) begin
      togglePrev <= 1'b0;
      synced     <= 1'b0;
      phase      <= '0;
    end else begin
      togglePrev <= slowToggle;
      if (slowToggle != togglePrev) begin
        phase  <= PH_AFTER_SEEN;
        synced <= 1'b1;
      end else if (phase == PH_LAST) begin
        phase <= '0;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  // Latched fault state: a trigger beats an arm in the same cycle
  always_ff @(posedge fastClk) begin
    if (rst)            tripped <= 1'b0;
    else if (faultTrig) tripped <= 1'b1;
    else if (rearm)     tripped <= 1'b0;
  end

  always_comb begin
    strobe.loadWord = synced && (phase == '0);
    strobe.blank    = tripped;
  end

endmodule

// File: rtl/sgs_datapath.sv
module sgs_datapath
  import serdes_gate_pkg::*;
#(
  parameter  int RATIO  = 4,
  localparam int CODE_W = 2 * RATIO
) (
  input  logic              slowClk,
  input  logic              fastClk,
  input  logic              rst,
  input  logic [CODE_W-1:0] codeIn,
  input  ctlStrobe_t        strobe,
  output logic              riseQ,
  output logic              fallQ,
  output logic              serOut
);

  // Input register plus two serializer stages gives three slow cycles to the pin
  localparam int SLOW_STAGES = 3;

  logic [CODE_W-1:0] stageQ [SLOW_STAGES];
  logic [CODE_W-1:0] wordQ;
  logic [CODE_W-1:0] nextSrc;
  logic              fallHold;

  always_ff @(posedge slowClk) begin
    if (rst) begin
      for (int i = 0; i < SLOW_STAGES; i++) stageQ[i] <= '0;
    end else begin
      stageQ[0] <= codeIn;
      for (int i = 1; i < SLOW_STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  // The bit pair comes from a fresh word on a slow edge, otherwise from the shifter
  always_comb begin
    nextSrc = strobe.loadWord ? stageQ[SLOW_STAGES-1] : wordQ;
  end

  always_ff @(posedge fastClk) begin
    if (rst) begin
      wordQ <= '0;
      riseQ <= 1'b0;
      fallQ <= 1'b0;
    end else begin
      wordQ <= nextSrc >> 2;
      riseQ <= nextSrc[0] & ~strobe.blank;
      fallQ <= nextSrc[1] & ~strobe.blank;
    end
  end

  // Hold the odd bit across the low phase
  always_ff @(negedge fastClk) begin
    if (rst) fallHold <= 1'b0;
    else     fallHold <= fallQ;
  end

  // Double-data-rate output: even bit in the high phase, odd bit in the low phase
  always_comb begin
    if (rst)          serOut = 1'b0;
    else if (fastClk) serOut = riseQ;
    else              serOut = fallHold;
  end

endmodule

// File: rtl/fault_gated_serializer.sv
module fault_gated_serializer
  import serdes_gate_pkg::*;
#(
  parameter  int RATIO  = 4,
  localparam int CODE_W = 2 * RATIO
) (
  input  logic              slowClk,
  input  logic              fastClk,
  input  logic              rst,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              faultTrig,
  input  logic              rearm,
  output logic              serOut
);

  ctlStrobe_t strobe;
  logic       riseQ;
  logic       fallQ;

  sgs_ctl #(.RATIO(RATIO)) u_ctl (
    .slowClk   (slowClk),
    .fastClk   (fastClk),
    .rst       (rst),
    .faultTrig (faultTrig),
    .rearm     (rearm),
    .strobe    (strobe)
  );

  sgs_datapath #(.RATIO(RATIO)) u_dp (
    .slowClk (slowClk),
    .fastClk (fastClk),
    .rst     (rst),
    .codeIn  (codeIn),
    .strobe  (strobe),
    .riseQ   (riseQ),
    .fallQ   (fallQ),
    .serOut  (serOut)
  );

endmodule

// File: rtl/sgs_checker.sv
module sgs_checker
  import serdes_gate_pkg::*;
(
  input logic       fastClk,
  input logic       rst,
  input logic       faultTrig,
  input logic       rearm,
  input ctlStrobe_t strobe,
  input logic       riseQ,
  input logic       fallQ
);

  // R5: a sampled trigger always leaves the fault latched
  a_r5_trip_latch: assert property (@(posedge fastClk) disable iff (rst)
    faultTrig |=> strobe.blank);

  // R5 and R7: the fault holds until an arm pulse arrives
  a_r5_trip_hold: assert property (@(posedge fastClk) disable iff (rst)
    (strobe.blank && !rearm) |=> strobe.blank);

  // R5: while faulted, the datapath loads only zero bit pairs
  a_r5_blank_gates_pair: assert property (@(posedge fastClk) disable iff (rst)
    strobe.blank |=> (!riseQ && !fallQ));

  // R6: an arm pulse without a trigger clears the fault
  a_r6_rearm_release: assert property (@(posedge fastClk) disable iff (rst)
    (strobe.blank && rearm && !faultTrig) |=> !strobe.blank);

  // R8: without a trigger, the armed state persists whatever rearm does
  a_r8_idle_stays_armed: assert property (@(posedge fastClk) disable iff (rst)
    (!strobe.blank && !faultTrig) |=> !strobe.blank);

  // R3: word loads occur on slow edges only, never on two fast edges in a row
  a_r3_load_spacing: assert property (@(posedge fastClk) disable iff (rst)
    strobe.loadWord |=> !strobe.loadWord);

endmodule

bind fault_gated_serializer sgs_checker u_chk (
  .fastClk   (fastClk),
  .rst       (rst),
  .faultTrig (faultTrig),
  .rearm     (rearm),
  .strobe    (strobe),
  .riseQ     (riseQ),
  .fallQ     (fallQ)
);

// File: tb/test_fault_gated_serializer.sv
module test_fault_gated_serializer;
  timeunit 1ps;
  timeprecision 1ps;

  localparam int FAST_PERIOD = 1600;
  localparam int HALF        = FAST_PERIOD / 2;
  localparam int RATIO       = 4;
  localparam int CODE_W      = 2 * RATIO;
  localparam int NVEC        = 8;

  typedef struct packed {
    logic [7:0]  code;
    logic [7:0]  expWord;
    int unsigned widthPs;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{8'h01, 8'h01, 800},
    '{8'h03, 8'h03, 1600},
    '{8'h0F, 8'h0F, 3200},
    '{8'h7F, 8'h7F, 5600},
    '{8'hFF, 8'hFF, 6400},
    '{8'h00, 8'h00, 0},
    '{8'hA5, 8'hA5, 3200},
    '{8'h3C, 8'h3C, 3200}
  };

  logic              slowClk = 1'b0;
  logic              fastClk = 1'b0;
  logic              rst     = 1'b1;
  logic [CODE_W-1:0] codeIn  = '0;
  logic              faultTrig = 1'b0;
  logic              rearm   = 1'b0;
  logic              serOut;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;
  int fastRise = 0;

  fault_gated_serializer #(.RATIO(RATIO)) i_fault_gated_serializer (
    .slowClk   (slowClk),
    .fastClk   (fastClk),
    .rst       (rst),
    .codeIn    (codeIn),
    .faultTrig (faultTrig),
    .rearm     (rearm),
    .serOut    (serOut)
  );

  // Both clocks from one process so that their rising edges coincide
  initial begin
    forever begin
      #HALF;
      fastClk = ~fastClk;
      if (fastClk) begin
        if (fastRise % (RATIO / 2) == 0) slowClk = ~slowClk;
        fastRise++;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called just after a slow rising edge: samples the eight half-phase slots
  task automatic grabWord(output logic [7:0] w, output int highPs);
    highPs = 0;
    #(HALF / 2);
    for (int j = 0; j < 8; j++) begin
      w[j] = serOut;
      if (serOut === 1'b1) highPs += HALF;
      if (j < 7) #HALF;
    end
  endtask

  // Samples both halves of the next fast cycle and ends any single-cycle pulse
  task automatic sampleFast(output logic hi, output logic lo);
    @(posedge fastClk);
    #(HALF / 2);
    hi = serOut;
    faultTrig = 1'b0;
    rearm = 1'b0;
    #HALF;
    lo = serOut;
  endtask

  task automatic pulseCheck(input string tag, input logic expHi, input logic expLo);
    logic h, l;
    sampleFast(h, l);
    check(tag, {30'd0, h, l}, {30'd0, expHi, expLo});
  endtask

  initial begin
    #(FAST_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] w;
    int hp;

    // R1: pin low in reset even with an all-ones code applied
    codeIn = 8'hFF;
    repeat (4) @(posedge slowClk);
    for (int j = 0; j < 4; j++) begin
      #(HALF / 2);
      check("R1 low in reset", {31'd0, serOut}, 32'd0);
      #(HALF / 2);
    end
    codeIn = '0;
    @(negedge slowClk);
    #(HALF / 2);
    rst = 1'b0;

    // R1: nothing sampled before release reaches the pin
    for (int j = 0; j < 4; j++) begin
      @(posedge slowClk);
      grabWord(w, hp);
      check("R1 zero after release", {24'd0, w}, 32'd0);
    end

    // R2 R4 R10: vector table, back-to-back words
    @(negedge slowClk);
    codeIn = VEC[0].code;
    fork
      begin
        for (int i = 1; i < NVEC; i++) begin
          @(negedge slowClk);
          codeIn = VEC[i].code;
        end
        @(negedge slowClk);
        codeIn = '0;
      end
      begin
        @(posedge slowClk);
        repeat (3) @(posedge slowClk);
        for (int i = 0; i < NVEC; i++) begin
          if (i > 0) @(posedge slowClk);
          grabWord(w, hp);
          check("R2 R4 word order", {24'd0, w}, {24'd0, VEC[i].expWord});
          check("R10 high time ps", hp, VEC[i].widthPs);
        end
      end
    join

    // R3: a single-cycle code reaches the pin exactly three slow cycles later
    @(negedge slowClk);
    codeIn = 8'hFF;
    fork
      begin
        @(negedge slowClk);
        codeIn = '0;
      end
      begin
        for (int k = 0; k < 5; k++) begin
          @(posedge slowClk);
          grabWord(w, hp);
          check("R3 latency", {24'd0, w}, (k == 3) ? 32'hFF : 32'h0);
        end
      end
    join

    // Fault handling with a steady all-ones code
    @(negedge slowClk);
    codeIn = 8'hFF;
    repeat (5) @(posedge slowClk);
    pulseCheck("R5 baseline high", 1'b1, 1'b1);
    faultTrig = 1'b1;
    pulseCheck("R5 trigger cycle still data", 1'b1, 1'b1);
    pulseCheck("R5 blank next cycle", 1'b0, 1'b0);
    for (int j = 0; j < 10; j++) pulseCheck("R5 blank held", 1'b0, 1'b0);

    faultTrig = 1'b1;
    pulseCheck("R7 retrigger no effect", 1'b0, 1'b0);
    pulseCheck("R7 retrigger no effect", 1'b0, 1'b0);

    rearm = 1'b1;
    pulseCheck("R6 arm cycle still low", 1'b0, 1'b0);
    pulseCheck("R6 data resumes", 1'b1, 1'b1);
    pulseCheck("R6 data resumes", 1'b1, 1'b1);

    rearm = 1'b1;
    pulseCheck("R8 idle arm no effect", 1'b1, 1'b1);
    pulseCheck("R8 idle arm no effect", 1'b1, 1'b1);
    faultTrig = 1'b1;
    pulseCheck("R8 trigger after idle arm", 1'b1, 1'b1);
    pulseCheck("R8 trigger after idle arm", 1'b0, 1'b0);
    rearm = 1'b1;
    pulseCheck("R6 arm cycle still low", 1'b0, 1'b0);
    pulseCheck("R6 data resumes", 1'b1, 1'b1);

    faultTrig = 1'b1;
    rearm = 1'b1;
    pulseCheck("R9 both pulses cycle", 1'b1, 1'b1);
    pulseCheck("R9 trigger wins", 1'b0, 1'b0);
    for (int j = 0; j < 3; j++) pulseCheck("R9 stays blank", 1'b0, 1'b0);
    rearm = 1'b1;
    pulseCheck("R9 arm cycle low", 1'b0, 1'b0);
    pulseCheck("R9 released", 1'b1, 1'b1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule